// File: doc/BRIEF.md
# Frame-Synchronised TDM Converter Receiver

This block is the host-side end of a frame-synchronised, time-division-multiplexed link to a multi-channel delta-sigma converter. From the system clock it derives the converter master clock (half rate) and a slower serial clock. It issues a frame strobe at the start of every frame. One serial data line carries one 24-bit word per channel, most significant bit first.

A channel-enable mask and a position-mode select describe how the converter packs its frame. In fixed positioning every channel occupies a slot. In dynamic positioning, powered-down channels are left out and the remaining words are packed together. The receiver walks the mask to label each captured word with its true channel number.

Every completed word is presented with a one-cycle write strobe for a downstream FIFO. While that FIFO reports full, captures and writes are suppressed.

The frame length is a parameter. It must lie strictly between 256 and 2560 master-clock cycles, and it must hold `FS_SLOTS` and `NCH*WORD_W` serial-clock periods.

Top module: `tdm_frame_rx`

## Requirements
- R1: `mclk_o` is low in reset. It goes high at the first clock edge after reset is released and then toggles on every clock edge, giving half the system clock rate.
- R2: The frame repeats every `2*FRAME_MCLK` system clocks, with the first frame starting at reset release. Each serial period is `2*SCLK_DIV` system clocks. `fsync_o` is high for the first `FS_SLOTS` serial periods of each frame and low for the rest.
- R3: Serial period `s` of a frame is active when `s` is below the frame's bit count. In an active period `sclk_o` is low for the first `SCLK_DIV` system clocks and high for the rest. Outside active periods it idles high.
- R4: `sdata_i` is sampled at the clock edge on which `sclk_o` rises. Bits are shifted in MSB first, 24 per word. `word_o` takes the completed word at the edge that samples its last bit, and changes at no other edge.
- R5: Words per frame, and so the frame's bit count divided by 24, is `NCH` in fixed mode (`dyn_pos_i`=0). In dynamic mode (`dyn_pos_i`=1) it equals the number of set bits in `chan_en_i`. Both inputs are taken in the last clock of the previous frame, or during reset.
- R6: For the n-th word of a frame (counting from 0), `chan_o` is n in fixed mode. In dynamic mode it is the bit index of the n-th set bit of the mask, counting from bit 0 (channel 0) upward.
- R7: For each completed word, `wr_o` is high for exactly one clock. It is asserted after the second clock edge following the edge that completed the word.
- R8: If `fifo_full_i` is high at the completing edge, the word is dropped: `word_o` and `chan_o` keep their values and no strobe follows. If `fifo_full_i` is high at the edge that would raise `wr_o`, that strobe is suppressed.
- R9: While `rst_i` is high, `mclk_o`, `fsync_o`, `word_o`, `chan_o` and `wr_o` are 0 and `sclk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Serial data from the converter |
| chan_en_i | input | NCH | Channel-enable mask, bit i = channel i |
| dyn_pos_i | input | 1 | 1 = dynamic positioning, 0 = fixed |
| fifo_full_i | input | 1 | Downstream FIFO full |
| mclk_o | output | 1 | Converter master clock |
| sclk_o | output | 1 | Serial clock |
| fsync_o | output | 1 | Frame strobe |
| word_o | output | WORD_W | Last captured word |
| chan_o | output | $clog2(NCH) | Channel number of `word_o` |
| wr_o | output | 1 | One-clock write strobe |

## Verification
A corrupt frame or slot counter shows up at the very next clock edge as a misplaced `sclk_o` or `fsync_o` transition. This is because the bench compares the clock outputs with its own timing model every cycle. A wrong bit counter or shift register surfaces at the end of the current word: a word that is shifted, or that appears one serial period early or late, fails the `word_o` comparison at that edge.

A mask walk that drifts yields a wrong `chan_o` on the first affected word. Lost or doubled strobes are caught two cycles after the word completes, and again by the per-frame word count.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Number of set bits in a mask (up to 32 channels).
  function automatic int ones(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase #(
  parameter int NCH        = 8,
  parameter int WORD_W     = 24,
  parameter int FRAME_MCLK = 400,
  parameter int SCLK_DIV   = 2,
  parameter int FS_SLOTS   = 2
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           dyn_i,
  output logic [NCH-1:0] mask_q,
  output logic           dyn_q,
  output logic           mclk_o,
  output logic           sclk_o,
  output logic           fsync_o,
  output logic           smp_o,
  output logic           first_o
);
  import tdm_rx_pkg::*;

  localparam int FRAME_SYS = 2 * FRAME_MCLK;
  localparam int SCLK_SYS  = 2 * SCLK_DIV;
  localparam int NSLOT     = FRAME_SYS / SCLK_SYS + 1;
  localparam int FC_W      = $clog2(FRAME_SYS);
  localparam int P_W       = $clog2(SCLK_SYS);
  localparam int S_W       = $clog2(NSLOT + 1);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_SYS - 1);
  localparam logic [P_W-1:0]  PH_LAST = P_W'(SCLK_SYS - 1);
  localparam logic [P_W-1:0]  PH_RISE = P_W'(SCLK_DIV);
  localparam logic [S_W-1:0]  FS_END  = S_W'(FS_SLOTS);

  logic [FC_W-1:0] fc;
  logic [P_W-1:0]  ph;
  logic [S_W-1:0]  sl;
  logic [S_W-1:0]  nbits;
  logic            active;
  int              nwords;

  always_comb begin
    nwords = dyn_q ? ones(32'(mask_q)) : NCH;
    nbits  = S_W'(nwords * WORD_W);
  end

  assign active  = (sl < nbits);
  assign smp_o   = active && (ph == PH_RISE);
  assign first_o = (sl == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fc      <= '0;
      ph      <= '0;
      sl      <= '0;
      mclk_o  <= 1'b0;
      sclk_o  <= 1'b1;
      fsync_o <= 1'b0;
      mask_q  <= mask_i;
      dyn_q   <= dyn_i;
    end else begin
      mclk_o  <= ~fc[0];
      sclk_o  <= active ? (ph >= PH_RISE) : 1'b1;
      fsync_o <= (sl < FS_END);
      if (fc == FC_LAST) begin
        fc     <= '0;
        ph     <= '0;
        sl     <= '0;
        mask_q <= mask_i;
        dyn_q  <= dyn_i;
      end else begin
        fc <= fc + 1'b1;
        if (ph == PH_LAST) begin
          ph <= '0;
          sl <= sl + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_chan_map.sv
module tdm_chan_map #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0]           mask_i,
  input  logic                     dyn_i,
  input  logic [$clog2(NCH+1)-1:0] widx_i,
  output logic [$clog2(NCH)-1:0]   tag_o
);
  localparam int WI_W  = $clog2(NCH + 1);
  localparam int TAG_W = $clog2(NCH);

  logic [WI_W-1:0]  run;
  logic [TAG_W-1:0] dtag;

  // Scan upward: the enabled channel whose rank equals the word index wins.
  always_comb begin
    run  = '0;
    dtag = '0;
    for (int i = 0; i < NCH; i++) begin
      if (mask_i[i] && (run == widx_i)) dtag = TAG_W'(i);
      run = run + WI_W'(mask_i[i]);
    end
  end

  assign tag_o = dyn_i ? dtag : TAG_W'(widx_i);

endmodule

// File: rtl/tdm_word_capture.sv
module tdm_word_capture #(
  parameter int NCH    = 8,
  parameter int WORD_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     smp_i,
  input  logic                     first_i,
  input  logic                     sdata_i,
  input  logic                     full_i,
  input  logic [$clog2(NCH)-1:0]   tag_i,
  output logic [$clog2(NCH+1)-1:0] widx_o,
  output logic [WORD_W-1:0]        data_o,
  output logic [$clog2(NCH)-1:0]   tag_o,
  output logic                     wr_o
);
  localparam int BC_W = $clog2(WORD_W);
  localparam int WI_W = $clog2(NCH + 1);
  localparam logic [BC_W-1:0] B_LAST = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg, shifted;
  logic [BC_W-1:0]   bcnt, eff_b;
  logic [WI_W-1:0]   widx;
  logic              last, done, done_d1, done_d2;

  assign eff_b   = first_i ? '0 : bcnt;
  assign widx_o  = first_i ? '0 : widx;
  assign last    = (eff_b == B_LAST);
  assign shifted = {sreg[WORD_W-2:0], sdata_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sreg    <= '0;
      bcnt    <= '0;
      widx    <= '0;
      done    <= 1'b0;
      done_d1 <= 1'b0;
      done_d2 <= 1'b0;
      data_o  <= '0;
      tag_o   <= '0;
      wr_o    <= 1'b0;
    end else begin
      if (smp_i) begin
        sreg <= shifted;
        bcnt <= last ? '0 : eff_b + 1'b1;
        widx <= last ? widx_o + 1'b1 : widx_o;
        done <= last && !full_i;
        if (last && !full_i) begin
          data_o <= shifted;
          tag_o  <= tag_i;
        end
      end
      done_d1 <= done;
      done_d2 <= done_d1;
      wr_o    <= done_d1 && !done_d2 && !full_i;
    end
  end

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
  parameter int NCH        = 8,
  parameter int WORD_W     = 24,
  parameter int FRAME_MCLK = 400,
  parameter int SCLK_DIV   = 2,
  parameter int FS_SLOTS   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   sdata_i,
  input  logic [NCH-1:0]         chan_en_i,
  input  logic                   dyn_pos_i,
  input  logic                   fifo_full_i,
  output logic                   mclk_o,
  output logic                   sclk_o,
  output logic                   fsync_o,
  output logic [WORD_W-1:0]      word_o,
  output logic [$clog2(NCH)-1:0] chan_o,
  output logic                   wr_o
);
  logic [NCH-1:0]           cfg_mask;
  logic                     cfg_dyn;
  logic                     smp, first;
  logic [$clog2(NCH+1)-1:0] widx;
  logic [$clog2(NCH)-1:0]   tag;

  tdm_timebase #(
    .NCH(NCH), .WORD_W(WORD_W), .FRAME_MCLK(FRAME_MCLK),
    .SCLK_DIV(SCLK_DIV), .FS_SLOTS(FS_SLOTS)
  ) u_tb (
    .clk_i(clk_i), .rst_i(rst_i), .mask_i(chan_en_i), .dyn_i(dyn_pos_i),
    .mask_q(cfg_mask), .dyn_q(cfg_dyn), .mclk_o(mclk_o), .sclk_o(sclk_o),
    .fsync_o(fsync_o), .smp_o(smp), .first_o(first)
  );

  tdm_chan_map #(.NCH(NCH)) u_map (
    .mask_i(cfg_mask), .dyn_i(cfg_dyn), .widx_i(widx), .tag_o(tag)
  );

  tdm_word_capture #(.NCH(NCH), .WORD_W(WORD_W)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .smp_i(smp), .first_i(first),
    .sdata_i(sdata_i), .full_i(fifo_full_i), .tag_i(tag), .widx_o(widx),
    .data_o(word_o), .tag_o(chan_o), .wr_o(wr_o)
  );

endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
  parameter int NCH    = 8,
  parameter int WORD_W = 24
) (
  input logic                   clk_i,
  input logic                   rst_i,
  input logic                   fifo_full_i,
  input logic                   mclk_o,
  input logic                   sclk_o,
  input logic [WORD_W-1:0]      word_o,
  input logic [$clog2(NCH)-1:0] chan_o,
  input logic                   wr_o,
  input logic [NCH-1:0]         cfg_mask,
  input logic                   cfg_dyn
);
  // R1: master clock toggles every system clock outside reset
  a_r1_mclk_toggles: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (mclk_o != $past(mclk_o)));

  // R4: the output word only moves on a serial-clock rising edge
  a_r4_word_on_sclk_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(word_o)) |-> $rose(sclk_o));

  // R6: in dynamic mode every written word names an enabled channel
  a_r6_tag_enabled: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_o && cfg_dyn) |-> cfg_mask[chan_o]);

  // R7: write strobe lasts one clock
  a_r7_wr_single: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_o |=> !wr_o);

  // R8: no write follows an edge that saw the FIFO full
  a_r8_full_blocks_write: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_full_i |=> !wr_o);
endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(.NCH(NCH), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .fifo_full_i(fifo_full_i), .mclk_o(mclk_o),
  .sclk_o(sclk_o), .word_o(word_o), .chan_o(chan_o), .wr_o(wr_o),
  .cfg_mask(cfg_mask), .cfg_dyn(cfg_dyn)
);

// File: tb/test_tdm_frame_rx.sv
module test_tdm_frame_rx;
  localparam int NCH = 8, WORD_W = 24, FRAME_MCLK = 400, SCLK_DIV = 2, FS_SLOTS = 2;
  localparam int FSYS = 2 * FRAME_MCLK, SP = 2 * SCLK_DIV;

  logic clk = 1'b0, rst = 1'b1, sdata = 1'b0, dyn = 1'b0, full = 1'b0;
  logic [NCH-1:0] mask = '1;
  logic mclk, sclk, fsync, wr;
  logic [WORD_W-1:0] word;
  logic [2:0] chan;

  always #2 clk = ~clk;

  tdm_frame_rx #(.NCH(NCH), .WORD_W(WORD_W), .FRAME_MCLK(FRAME_MCLK),
                 .SCLK_DIV(SCLK_DIV), .FS_SLOTS(FS_SLOTS)) i_tdm_frame_rx (
    .clk_i(clk), .rst_i(rst), .sdata_i(sdata), .chan_en_i(mask), .dyn_pos_i(dyn),
    .fifo_full_i(full), .mclk_o(mclk), .sclk_o(sclk), .fsync_o(fsync),
    .word_o(word), .chan_o(chan), .wr_o(wr));

  int total = 0, fails = 0;
  bit finished = 0, started = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int tag_of(input logic [NCH-1:0] m, input bit d, input int n);
    int seen = 0;
    if (!d) return n;
    for (int i = 0; i < NCH; i++) if (m[i]) begin
      if (seen == n) return i;
      seen++;
    end
    return -1;
  endfunction

  // Behavioural reference model
  int t = 0, n = 0, obs = 0;
  int wrq[$];
  logic [NCH-1:0] m_mask;
  bit m_dyn, rst_edge, full_edge, clean;
  bit e_mclk, e_sclk, e_fsync, e_wr;
  logic [WORD_W-1:0] e_word, sr;
  int e_chan;

  always @(posedge clk) begin
    int s, p, nw, nb;
    started   = 1;
    rst_edge  = rst;
    full_edge = full;
    if (rst) begin
      t = 0; n = 0; obs = 0; clean = 1;
      e_mclk = 0; e_sclk = 1; e_fsync = 0; e_wr = 0; e_word = '0; e_chan = 0; sr = '0;
      wrq.delete();
      m_mask = mask; m_dyn = dyn;
    end else begin
      n++;
      s = t / SP; p = t % SP;
      nw = m_dyn ? $countones(m_mask) : NCH;
      nb = nw * WORD_W;
      e_mclk  = (t % 2 == 0);
      e_sclk  = (s < nb) ? (p >= SCLK_DIV) : 1'b1;
      e_fsync = (s < FS_SLOTS);
      e_wr    = 0;
      if (wrq.size() > 0 && wrq[0] == n) begin
        e_wr = !full;
        void'(wrq.pop_front());
      end
      if (full) clean = 0;
      if (p == SCLK_DIV && s < nb) begin
        sr = {sr[WORD_W-2:0], sdata};
        if (s % WORD_W == WORD_W - 1 && !full) begin
          e_word = sr;
          e_chan = tag_of(m_mask, m_dyn, s / WORD_W);
          wrq.push_back(n + 2);
        end
      end
      if (t == FSYS - 1) begin
        if (clean) chk(obs == nw, "R5 words per frame", obs, nw);
        obs = 0; clean = 1;
        m_mask = mask; m_dyn = dyn;
      end
      t = (t + 1) % FSYS;
    end
  end

  // Compare at every falling edge, then drive fresh serial data
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(mclk == e_mclk, rst_edge ? "R9 mclk" : "R1 mclk", mclk, e_mclk);
      chk(fsync == e_fsync, rst_edge ? "R9 fsync" : "R2 fsync", fsync, e_fsync);
      chk(sclk == e_sclk, rst_edge ? "R9 sclk" : "R3 sclk", sclk, e_sclk);
      chk(word == e_word, rst_edge ? "R9 word" : "R4 word", word, e_word);
      chk(int'(chan) == e_chan, rst_edge ? "R9 chan" : "R6 chan", chan, e_chan);
      chk(wr == e_wr, rst_edge ? "R9 wr" : "R7 wr", wr, e_wr);
      if (full_edge && !rst_edge) chk(wr == 1'b0, "R8 write held off", wr, 0);
      if (wr && !rst_edge) obs++;
    end
    sdata <= 1'($urandom);
  end

  task automatic run(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    run(4); rst = 0;
    run(1700);                                  // fixed mode, all channels
    dyn = 1; mask = 8'b1010_0110; run(1600);    // dynamic, tags 1,2,5,7
    mask = 8'h80; run(1600);                    // single top channel
    mask = 8'h00; run(1600);                    // nothing enabled: serial clock idles
    dyn = 0; mask = 8'h05; run(1600);           // fixed mode ignores mask for count
    dyn = 1; mask = 8'h3C; run(300);
    full = 1; run(200); full = 0; run(1300);    // R8 window
    run(250); rst = 1; run(3); rst = 0; run(1700); // reset mid-frame, R9
    mask = 8'h01; run(1600);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule